// File: doc/BRIEF.md
# Configurable SPI Frame Master

This block drives one SPI channel as a master and moves exactly one frame for each start request. It latches the transmit word and a 23-bit mode word when a start is accepted, and then runs the frame with those settings: SCLK idle level, which edge shifts and which samples, bit order, a frame length of 2 to 32 data bits, an optional parity bit, the chip-select polarity, and three separate chip-select gaps counted in half SCLK periods. One half SCLK period lasts `HALF_DIV` system clocks, so the SCLK rate is the system clock divided by 2·`HALF_DIV`.

In the mode word, bit 0 is clock polarity, bit 1 is clock phase, bit 2 is MSB-first and bits 8:3 are the frame width. Bit 9 makes chip select active high. Bits 12:10 hold the lead gap, bits 15:13 the trail gap and bits 18:16 the inactive gap. Bit 19 enables parity and bit 20 selects odd parity. Bit 21 turns on loopback and bit 22 hands chip select to the hardware sequencer.

After a frame, the received word stays on `rx_data_o` until the next accepted start. `done_o` pulses once in the first cycle in which chip select is inactive. `perr_o` can only be high together with `done_o`. `busy_o` covers the whole frame, including the inactive gap that follows it. A start request that arrives while the block is busy has no effect.

Top module: `spi_frame_master`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0. `sclk_o` equals mode bit 0. With mode bit 22 set, `cs_o` is at its inactive level (high when mode bit 9 is 0).
- R2: While no frame runs, `sclk_o` rests at mode bit 0 (0 means idle low, 1 means idle high). After the last edge of a frame it returns to that level.
- R3: With mode bit 1 = 0, the first bit is on `mosi_o` from the moment chip select asserts. Leading edges sample and trailing edges shift. With mode bit 1 = 1, leading edges shift and trailing edges sample. Each frame has exactly two SCLK edges per bit.
- R4: When mode bit 2 = 1, data goes out and is assembled MSB first. When it is 0, LSB first. The order is the same for transmit and receive.
- R5: The frame carries W data bits, where W is mode bits 8:3. A value below 2 acts as 2 and a value above 32 acts as 32. Received bits at W and above read 0.
- R6: With mode bit 22 = 1, the sequencer drives chip select. With it 0, `cs_o` follows `sw_cs_i`, where 1 means active. Mode bit 9 = 1 makes the active level high, and 0 makes it low.
- R7: The first SCLK edge comes (lead+1)·HALF_DIV clocks after chip select asserts.
- R8: Chip select deasserts trail·HALF_DIV clocks after the last SCLK edge. `done_o` is high for exactly one cycle, and that cycle is the first one with chip select inactive.
- R9: `busy_o` falls gap·HALF_DIV+1 clocks after `done_o` rises. A start request while `busy_o` is 1 is ignored, so no frame starts and the latched data stays as it was.
- R10: With mode bit 19 = 1, one parity bit follows the data bits. It is even parity when bit 20 = 0 and odd parity when bit 20 = 1.
- R11: With parity enabled, one parity bit is received. `perr_o` goes high with `done_o` when the data bits plus the received parity bit fail the selected parity. Otherwise `perr_o` stays 0.
- R12: With mode bit 21 = 1, the receive path takes `mosi_o` instead of `miso_i`.
- R13: `busy_o` is 1 from the cycle after an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame request, taken when idle |
| tx_data_i | input | 32 | Word to transmit |
| mode_i | input | 23 | Frame settings word |
| sw_cs_i | input | 1 | Chip-select request when software-held |
| miso_i | input | 1 | Serial data from the slave |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| cs_o | output | 1 | Chip select |
| rx_data_o | output | 32 | Assembled received word |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| busy_o | output | 1 | Frame or its gaps in progress |
| perr_o | output | 1 | Parity mismatch, valid with done |

## Verification
Every result has a due time in clocks. `busy_o` is due one cycle after the accepted start. The first SCLK edge is due (lead+1)·HALF_DIV clocks after chip select asserts. Chip select releases trail·HALF_DIV clocks after the last edge, and `done_o`, `rx_data_o` and `perr_o` are due in that same cycle. `busy_o` drops gap·HALF_DIV+1 clocks later. The bench samples every output on the falling clock edge and timestamps each event with a cycle counter, then compares the differences between timestamps with these formulas. Its slave model moves MISO only on the shift edges that the requirements define, so each sample edge sees settled data.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam int WMAX   = 32;
  localparam int MODE_W = 23;
  localparam int SLOT_W = 6;

  typedef struct packed {
    logic       hw_cs;
    logic       loopback;
    logic       par_odd;
    logic       par_en;
    logic [2:0] gap;
    logic [2:0] trail;
    logic [2:0] lead;
    logic       cs_high;
    logic [5:0] width;
    logic       msb_first;
    logic       cpha;
    logic       cpol;
  } spim_mode_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_XFER, ST_TRAIL, ST_FIN, ST_GAP
  } spim_state_t;

  function automatic logic [SLOT_W-1:0] eff_width(input logic [5:0] w);
    if (w < 6'd2)  return 6'd2;
    if (w > 6'd32) return 6'd32;
    return w;
  endfunction

  function automatic logic [SLOT_W-1:0] frame_bits(input spim_mode_t m);
    return eff_width(m.width) + {5'd0, m.par_en};
  endfunction

  function automatic logic [4:0] bit_pos(input logic [SLOT_W-1:0] w,
                                         input logic msb,
                                         input logic [SLOT_W-1:0] k);
    logic [SLOT_W-1:0] p;
    p = msb ? (w - 6'd1 - k) : k;
    return p[4:0];
  endfunction

  function automatic logic parity_of(input logic [WMAX-1:0] d,
                                     input logic [SLOT_W-1:0] w);
    logic p;
    p = 1'b0;
    for (int i = 0; i < WMAX; i++) begin
      if (i < int'(w)) p = p ^ d[i];
    end
    return p;
  endfunction

  function automatic logic [2:0] minus_one(input logic [2:0] v);
    return v - 3'd1;
  endfunction

endpackage

// File: rtl/spim_tick.sv
module spim_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  spim_mode_t      mode_i,
  input  logic [WMAX-1:0] tx_i,
  input  logic            tick_i,
  output spim_state_t     state_o,
  output spim_mode_t      cfg_o,
  output logic [WMAX-1:0] tx_o,
  output logic            load_o,
  output logic            run_o,
  output logic            shift_ev_o,
  output logic            sample_ev_o,
  output logic            tog_o
);
  spim_state_t       state_q;
  spim_mode_t        cfg_q;
  logic [WMAX-1:0]   tx_q;
  logic [2:0]        cnt_q;
  logic [SLOT_W:0]   h_q;
  logic              tog_q;

  logic [SLOT_W-1:0] nbits;
  logic [SLOT_W:0]   last_h;
  logic              xfer_tick;
  logic              lead_half;

  assign nbits     = frame_bits(cfg_q);
  assign last_h    = {nbits, 1'b0} - 1'b1;
  assign xfer_tick = (state_q == ST_XFER) && tick_i;
  assign lead_half = ~h_q[0];
  assign load_o    = start_i && (state_q == ST_IDLE);
  assign run_o     = (state_q == ST_LEAD) || (state_q == ST_XFER) ||
                     (state_q == ST_TRAIL) || (state_q == ST_GAP);

  assign sample_ev_o = xfer_tick && (cfg_q.cpha ? ~lead_half : lead_half);
  assign shift_ev_o  = xfer_tick && (cfg_q.cpha ? (lead_half && (h_q != '0))
                                                : (~lead_half && (h_q != last_h)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      tx_q    <= '0;
      cnt_q   <= '0;
      h_q     <= '0;
      tog_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          cfg_q <= mode_i;
          tx_q  <= tx_i;
          h_q   <= '0;
          tog_q <= 1'b0;
          if (mode_i.lead == 3'd0) state_q <= ST_XFER;
          else begin
            state_q <= ST_LEAD;
            cnt_q   <= minus_one(mode_i.lead);
          end
        end
        ST_LEAD: if (tick_i) begin
          if (cnt_q == 3'd0) state_q <= ST_XFER;
          else               cnt_q   <= cnt_q - 3'd1;
        end
        ST_XFER: if (tick_i) begin
          tog_q <= ~tog_q;
          h_q   <= h_q + 1'b1;
          if (h_q == last_h) begin
            if (cfg_q.trail == 3'd0) state_q <= ST_FIN;
            else begin
              state_q <= ST_TRAIL;
              cnt_q   <= minus_one(cfg_q.trail);
            end
          end
        end
        ST_TRAIL: if (tick_i) begin
          if (cnt_q == 3'd0) state_q <= ST_FIN;
          else               cnt_q   <= cnt_q - 3'd1;
        end
        ST_FIN: begin
          if (cfg_q.gap == 3'd0) state_q <= ST_IDLE;
          else begin
            state_q <= ST_GAP;
            cnt_q   <= minus_one(cfg_q.gap);
          end
        end
        ST_GAP: if (tick_i) begin
          if (cnt_q == 3'd0) state_q <= ST_IDLE;
          else               cnt_q   <= cnt_q - 3'd1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign cfg_o   = cfg_q;
  assign tx_o    = tx_q;
  assign tog_o   = tog_q;

  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (state_q != ST_IDLE)) |=> ($stable(tx_q) && $stable(cfg_q))); // R9
  AST_BUSY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (state_q != ST_IDLE)); // R13
  AST_SCLK_HOME_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FIN) |-> !tog_q); // R2
  AST_ONE_EVENT_PER_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shift_ev_o && sample_ev_o)); // R3

endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            shift_ev_i,
  input  logic            sample_ev_i,
  input  spim_mode_t      cfg_i,
  input  logic [WMAX-1:0] tx_i,
  input  logic            miso_i,
  output logic            mosi_o,
  output logic [WMAX-1:0] rx_o,
  output logic            par_err_o
);
  logic [SLOT_W-1:0] txi_q;
  logic [SLOT_W-1:0] rxi_q;
  logic [WMAX-1:0]   rx_q;
  logic              rxpar_q;

  logic [SLOT_W-1:0] w;
  logic              tx_par;
  logic              rx_in;

  assign w      = eff_width(cfg_i.width);
  assign tx_par = parity_of(tx_i, w) ^ cfg_i.par_odd;
  assign mosi_o = (txi_q < w) ? tx_i[bit_pos(w, cfg_i.msb_first, txi_q)] : tx_par;
  assign rx_in  = cfg_i.loopback ? mosi_o : miso_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txi_q   <= '0;
      rxi_q   <= '0;
      rx_q    <= '0;
      rxpar_q <= 1'b0;
    end else if (load_i) begin
      txi_q   <= '0;
      rxi_q   <= '0;
      rx_q    <= '0;
      rxpar_q <= 1'b0;
    end else begin
      if (shift_ev_i) txi_q <= txi_q + 1'b1;
      if (sample_ev_i) begin
        rxi_q <= rxi_q + 1'b1;
        if (rxi_q < w) rx_q[bit_pos(w, cfg_i.msb_first, rxi_q)] <= rx_in;
        else           rxpar_q <= rx_in;
      end
    end
  end

  assign rx_o      = rx_q;
  assign par_err_o = cfg_i.par_en && ((parity_of(rx_q, w) ^ rxpar_q) != cfg_i.par_odd);

  AST_RX_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_ev_i |-> (rxi_q < frame_bits(cfg_i))); // R5
  AST_TX_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_ev_i |-> ((txi_q + 1'b1) < frame_bits(cfg_i))); // R10

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spim_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WMAX-1:0]   tx_data_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              sw_cs_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              cs_o,
  output logic [WMAX-1:0]   rx_data_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              perr_o
);
  spim_mode_t      mode_in;
  spim_mode_t      cfg_q;
  spim_mode_t      cfg_live;
  spim_state_t     state;
  logic [WMAX-1:0] tx_q;
  logic            load, run, tick, shift_ev, sample_ev, tog;
  logic            par_err;
  logic            frame_cs;
  logic            cs_on;

  assign mode_in = spim_mode_t'(mode_i);

  spim_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  spim_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mode_i      (mode_in),
    .tx_i        (tx_data_i),
    .tick_i      (tick),
    .state_o     (state),
    .cfg_o       (cfg_q),
    .tx_o        (tx_q),
    .load_o      (load),
    .run_o       (run),
    .shift_ev_o  (shift_ev),
    .sample_ev_o (sample_ev),
    .tog_o       (tog)
  );

  spim_shift u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .shift_ev_i  (shift_ev),
    .sample_ev_i (sample_ev),
    .cfg_i       (cfg_q),
    .tx_i        (tx_q),
    .miso_i      (miso_i),
    .mosi_o      (mosi_o),
    .rx_o        (rx_data_o),
    .par_err_o   (par_err)
  );

  assign busy_o   = (state != ST_IDLE);
  assign cfg_live = busy_o ? cfg_q : mode_in;
  assign frame_cs = (state == ST_LEAD) || (state == ST_XFER) || (state == ST_TRAIL);
  assign cs_on    = cfg_live.hw_cs ? frame_cs : sw_cs_i;
  assign cs_o     = cfg_live.cs_high ? cs_on : ~cs_on;
  assign sclk_o   = cfg_live.cpol ^ tog;
  assign done_o   = (state == ST_FIN);
  assign perr_o   = done_o && par_err;

  AST_SCLK_IDLE_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_cs |-> (sclk_o == cfg_live.cpol)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_PERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_o |-> done_o); // R11
  AST_DONE_CS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cfg_q.hw_cs) |-> (cs_o != cfg_q.cs_high)); // R8
  AST_TICK_ONLY_RUNNING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |-> busy_o); // R9

endmodule

// File: tb/test_spi_frame_master.sv
module test_spi_frame_master;
  import spim_pkg::*;

  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] tx_w = '0;
  logic [22:0] mode_w = '0;
  logic        sw_cs = 1'b0;
  logic        miso;
  logic        sclk_o, mosi_o, cs_o, done_o, busy_o, perr_o;
  logic [31:0] rx_data_o;

  always #2 clk = ~clk;

  spi_frame_master #(.HALF_DIV(HALF)) i_spi_frame_master (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tx_data_i(tx_w),
    .mode_i(mode_w), .sw_cs_i(sw_cs), .miso_i(miso), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .cs_o(cs_o), .rx_data_o(rx_data_o), .done_o(done_o),
    .busy_o(busy_o), .perr_o(perr_o)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  spim_mode_t  m;
  logic [31:0] slave_word = '0;
  logic        bad_par = 1'b0;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int wclamp(input int w);
    if (w < 2) return 2;
    if (w > 32) return 32;
    return w;
  endfunction

  function automatic logic wire_bit(input logic [31:0] d, input int k, input logic flip);
    int w;
    logic p;
    w = wclamp(int'(m.width));
    if (k < w) return m.msb_first ? d[w-1-k] : d[k];
    p = m.par_odd ^ flip;
    for (int i = 0; i < w; i++) p = p ^ d[i];
    return p;
  endfunction

  // slave model and event timestamps, sampled on the falling edge
  int          edges = 0, ncap = 0, ndone = 0, ncs = 0;
  int          t_cs_on = 0, t_first = 0, t_last = 0, t_cs_off = 0, t_done = 0, t_busy_off = 0;
  logic [32:0] cap_vec = '0;
  logic [31:0] done_rx = '0;
  logic        done_perr = 1'b0;
  logic        p_sclk = 1'b0, p_act = 1'b0, p_done = 1'b0, p_busy = 1'b0;
  initial miso = 1'b0;

  always @(negedge clk) begin
    logic act;
    act = (cs_o == m.cs_high);
    if (p_act && (sclk_o != p_sclk)) begin
      edges = edges + 1;
      if (edges == 1) t_first = cyc;
      t_last = cyc;
      if (m.cpha ? (edges % 2 == 0) : (edges % 2 == 1)) begin
        if (ncap < 33) cap_vec[ncap] = mosi_o;
        ncap = ncap + 1;
      end
      if (!m.cpha && (edges % 2 == 0)) miso = wire_bit(slave_word, edges / 2, bad_par);
      if (m.cpha && (edges % 2 == 1))  miso = wire_bit(slave_word, (edges - 1) / 2, bad_par);
    end
    if (!p_act && act) begin
      t_cs_on = cyc; edges = 0; ncap = 0; cap_vec = '0; ncs = ncs + 1;
      miso = wire_bit(slave_word, 0, bad_par);
    end
    if (p_act && !act) t_cs_off = cyc;
    if (done_o && !p_done) begin
      t_done = cyc; ndone = ndone + 1; done_rx = rx_data_o; done_perr = perr_o;
    end
    if (p_busy && !busy_o) t_busy_off = cyc;
    p_sclk = sclk_o; p_act = act; p_done = done_o; p_busy = busy_o;
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_frame(input spim_mode_t mm, input logic [31:0] tx, input logic [31:0] sw, input logic badp);
    m = mm; slave_word = sw; bad_par = badp; mode_w = mm; tx_w = tx;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R13", "busy after start", busy_o, 1);
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_frame(input logic [31:0] tx, input logic [31:0] exp_rx, input logic exp_perr, input int done_before);
    int w, n;
    logic [32:0] exp_vec;
    logic [31:0] wmask;
    w = wclamp(int'(m.width));
    n = w + int'(m.par_en);
    exp_vec = '0; wmask = '0;
    for (int k = 0; k < n; k++) exp_vec[k] = wire_bit(tx, k, 1'b0);
    for (int k = 0; k < w; k++) wmask[k] = 1'b1;
    chk("R5",  "slot count", ncap, n);
    chk("R4",  "mosi bit order", cap_vec, exp_vec);
    chk("R4",  "rx word", done_rx, exp_rx & wmask);
    chk("R11", "perr at done", done_perr, exp_perr);
    chk("R7",  "lead clocks", t_first - t_cs_on, (int'(m.lead) + 1) * HALF);
    chk("R8",  "trail clocks", t_cs_off - t_last, int'(m.trail) * HALF);
    chk("R8",  "done with cs off", t_done - t_cs_off, 0);
    chk("R8",  "one done pulse", ndone - done_before, 1);
    chk("R9",  "gap clocks", t_busy_off - t_done, int'(m.gap) * HALF + 1);
    chk("R2",  "sclk idle after frame", sclk_o, m.cpol);
  endtask

  function automatic spim_mode_t mk(input logic cpol, input logic cpha, input logic msb, input int w,
                                    input int ld, input int tr, input int gp);
    spim_mode_t r;
    r = '0;
    r.cpol = cpol; r.cpha = cpha; r.msb_first = msb; r.width = 6'(w);
    r.lead = 3'(ld); r.trail = 3'(tr); r.gap = 3'(gp); r.hw_cs = 1'b1;
    return r;
  endfunction

  task automatic t_reset;
    chk("R1", "busy at reset", busy_o, 0);
    chk("R1", "done at reset", done_o, 0);
    chk("R1", "sclk at reset", sclk_o, 1);
    chk("R1", "cs at reset", cs_o, 1);
  endtask

  task automatic t_mode0_msb;
    int d = ndone;
    do_frame(mk(0, 0, 1, 8, 0, 0, 0), 32'h0000_00A5, 32'h0000_003C, 0);
    check_frame(32'h0000_00A5, 32'h0000_003C, 0, d); // R3 phase 0
  endtask

  task automatic t_mode3_lsb;
    int d = ndone;
    do_frame(mk(1, 1, 0, 13, 2, 3, 1), 32'h0000_1B6D, 32'h0000_0F0F, 0);
    check_frame(32'h0000_1B6D, 32'h0000_0F0F, 0, d); // R3 phase 1
  endtask

  task automatic t_full_width;
    int d = ndone;
    do_frame(mk(0, 1, 1, 32, 7, 7, 7), 32'hDEAD_BEEF, 32'h1234_5678, 0);
    check_frame(32'hDEAD_BEEF, 32'h1234_5678, 0, d); // R5 upper bound
  endtask

  task automatic t_width_clamp;
    int d = ndone;
    do_frame(mk(1, 0, 0, 1, 1, 0, 2), 32'hFFFF_FFFE, 32'hFFFF_FFFD, 0);
    check_frame(32'hFFFF_FFFE, 32'hFFFF_FFFD, 0, d); // R5 below 2
    d = ndone;
    do_frame(mk(0, 0, 0, 45, 0, 1, 0), 32'h8000_0001, 32'hC000_0003, 0);
    check_frame(32'h8000_0001, 32'hC000_0003, 0, d); // R5 above 32
  endtask

  task automatic t_parity;
    spim_mode_t pm;
    int d;
    pm = mk(0, 0, 1, 9, 1, 1, 0); pm.par_en = 1'b1;
    d = ndone; do_frame(pm, 32'h0000_0155, 32'h0000_00F1, 0);
    check_frame(32'h0000_0155, 32'h0000_00F1, 0, d); // R10 even
    pm.par_odd = 1'b1;
    d = ndone; do_frame(pm, 32'h0000_0155, 32'h0000_00F1, 0);
    check_frame(32'h0000_0155, 32'h0000_00F1, 0, d); // R10 odd
    d = ndone; do_frame(pm, 32'h0000_0003, 32'h0000_0101, 1);
    check_frame(32'h0000_0003, 32'h0000_0101, 1, d); // R11 mismatch
  endtask

  task automatic t_loopback;
    spim_mode_t lm;
    int d;
    lm = mk(1, 0, 1, 16, 0, 0, 0); lm.loopback = 1'b1;
    d = ndone; do_frame(lm, 32'h0000_C3A9, 32'h0000_3C56, 0);
    check_frame(32'h0000_C3A9, 32'h0000_C3A9, 0, d); // R12
  endtask

  task automatic t_busy_ignore;
    int d, c;
    spim_mode_t other;
    m = mk(0, 0, 1, 12, 1, 1, 3); slave_word = 32'h0000_0ABC; bad_par = 0;
    mode_w = m; tx_w = 32'h0000_0963;
    d = ndone; c = ncs;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    other = mk(0, 0, 0, 4, 0, 0, 0);
    mode_w = other; tx_w = 32'h0000_000F; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (busy_o) @(negedge clk);
    @(negedge clk);
    check_frame(32'h0000_0963, 32'h0000_0ABC, 0, d); // R9 first frame intact
    repeat (40) @(negedge clk);
    chk("R9", "no extra frame", ncs - c, 1);
    chk("R9", "busy stays low", busy_o, 0);
  endtask

  task automatic t_sw_cs;
    spim_mode_t sm;
    sm = mk(0, 0, 1, 8, 0, 0, 0); sm.hw_cs = 1'b0; sm.cs_high = 1'b1;
    m = sm; mode_w = sm;
    sw_cs = 1'b1; @(negedge clk);
    chk("R6", "sw cs active high", cs_o, 1);
    sw_cs = 1'b0; @(negedge clk);
    chk("R6", "sw cs released", cs_o, 0);
    sm.cs_high = 1'b0; mode_w = sm; @(negedge clk);
    chk("R6", "sw cs inactive low-level", cs_o, 1);
    sw_cs = 1'b1; @(negedge clk);
    chk("R6", "sw cs active low", cs_o, 0);
    sw_cs = 1'b0;
    sm = mk(1, 0, 1, 8, 0, 0, 0); sm.cs_high = 1'b1; m = sm; mode_w = sm; @(negedge clk);
    chk("R6", "hw cs idle high-active", cs_o, 0);
    chk("R2", "idle high sclk", sclk_o, 1);
    sm.cpol = 1'b0; m = sm; mode_w = sm; @(negedge clk);
    chk("R2", "idle low sclk", sclk_o, 0);
  endtask

  initial begin
    m = mk(1, 0, 1, 8, 0, 0, 0);
    mode_w = m;
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_mode0_msb;
    t_mode3_lsb;
    t_full_width;
    t_width_clamp;
    t_parity;
    t_loopback;
    t_busy_ignore;
    t_sw_cs;
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule